// File: doc/BRIEF.md
# Network Interface Power-State Controller

This block manages the power states of a memory-mapped network interface. It has one run state and two sleep states, a light doze and a deep off. From the state it derives clock-enable outputs for the PHY, for the wake-detection part of the MAC, for the rest of the MAC and for the core logic. It also gates host register traffic with a ready flag. The host picks a sleep state through a two-bit mode field in a control/status register. A write of any value to a dedicated wake register brings the block back to run. Ready then stays low for a fixed resume delay while the clocks restart.

In doze, wake-frame and magic-packet detect pulses from the frame filters are armed automatically. A detection records a wake status, sets a PME interrupt-status bit, and can drive the PME pin and the host interrupt. Writes are also held off after reset and after every wake until the host has completed one read. Configuration contents stay unchanged across every power transition.

The host bus uses plain strobes with no back-pressure. A read is taken in the cycle its strobe is high, and an accepted read always returns data one cycle later with `host_rvalid` high. A read that is refused gets no response at all. Writes are single-cycle and never stall.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Reset leaves the block in run with mode 00, all enable bits and status clear, all four clock enables high and ready low. Ready rises on its own RESUME_CYC cycles after reset is released.
- R2: In run with ready set and writes unlocked, a control write selects the state through mode bits [13:12]: 01 enters doze and 10 enters off, and either one clears ready. The value 11 is reserved: the state stays run, the mode reads 00 and ready stays set.
- R3: While ready is low, only a read of the control register gets a response. A read of any other address produces no `host_rvalid`.
- R4: While ready is low, every write other than one to the wake register is dropped. The scratch and control contents are unchanged afterwards.
- R5: In doze or off, a write of any data to the wake register returns the block to run with mode 00. A read sampled RESUME_CYC cycles after the wake write still shows ready low, and the read one cycle later shows ready set. The same write issued in run has no effect.
- R6: Clock enables are bit0 PHY, bit1 MAC wake logic, bit2 rest of MAC, bit3 core. In run all four are high, in doze only bit0 and bit1 are high, and in off all four are low.
- R7: A frame or magic-packet detect pulse in doze sets the wake status (bits [5:4]) to 10 and the PME interrupt-status bit (bit 16). The same pulses in run or off change nothing.
- R8: `pme_o` is high only while the wake status holds 10 and both the PME enable (bit 1) and the wake-on-LAN enable (bit 2) are set.
- R9: `irq_o` is high while the PME interrupt-status bit and the interrupt enable (bit 3) are both set.
- R10: After reset and after each wake, writes are refused, even once ready is set, until one read has been accepted.
- R11: Wake-status bits and the PME interrupt-status bit are cleared by writing 1 to them. This takes effect only in run with ready set and writes unlocked.
- R12: The scratch register and the enable bits keep their values across doze, off and wake.
- R13: An accepted read returns data one cycle after the strobe. The control register reads as ready at bit 0 and then the fields listed above. The scratch register returns its contents and the wake register returns WAKE_PATTERN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after an accepted read |
| wake_frame_det | input | 1 | Wake-frame detect pulse |
| magic_pkt_det | input | 1 | Magic-packet detect pulse |
| pme_o | output | 1 | Power-management event pin |
| irq_o | output | 1 | Host interrupt |
| phy_clk_en | output | 1 | PHY clock enable |
| mac_wake_clk_en | output | 1 | MAC wake-detection clock enable |
| mac_clk_en | output | 1 | Remaining MAC clock enable |
| core_clk_en | output | 1 | Core logic clock enable |

## Verification
The hardest state to reach is the one where ready is already set but writes are still refused. Getting there means leaving reset or a wake in the off state and then making no read at all during the resume delay and for some cycles after it. The stimulus waits well past the delay without any access, issues a scratch write, and then reads the scratch back to show the write was dropped. A second case is a wake write that lands exactly when a ready probe is sampled. This is covered by probes sampled one cycle before and one cycle after ready is due to rise.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'b00,
    PS_DOZE = 2'b01,
    PS_OFF  = 2'b10
  } pstate_e;

  localparam int CF_RDY    = 0;
  localparam int CF_PME_EN = 1;
  localparam int CF_WOL_EN = 2;
  localparam int CF_IRQ_EN = 3;
  localparam int CF_WST    = 4;
  localparam int CF_MODE   = 12;
  localparam int CF_PINT   = 16;

  function automatic logic [31:0] ctrl_pack(
    input logic       rdy,
    input logic [2:0] en,
    input logic [1:0] wst,
    input pstate_e    mode,
    input logic       pint
  );
    logic [31:0] w;
    w                    = '0;
    w[CF_RDY]            = rdy;
    w[CF_IRQ_EN:CF_PME_EN] = en;
    w[CF_WST+1:CF_WST]   = wst;
    w[CF_MODE+1:CF_MODE] = mode;
    w[CF_PINT]           = pint;
    return w;
  endfunction

endpackage

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwrctl_pkg::*;
#(
  parameter int RESUME_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] mode_req,
  input  logic       wake_wr,
  input  logic       rd_ok,
  output pstate_e    pstate,
  output logic       rdy,
  output logic       wr_lock
);
  localparam int CW = $clog2(RESUME_CYC + 1);

  logic [CW-1:0] cnt;
  logic          go_sleep;

  assign go_sleep = ctrl_wr && (mode_req == PS_DOZE || mode_req == PS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= PS_RUN;
      rdy    <= 1'b0;
      cnt    <= CW'(RESUME_CYC);
    end else if (wake_wr) begin
      pstate <= PS_RUN;
      rdy    <= 1'b0;
      cnt    <= CW'(RESUME_CYC);
    end else if (go_sleep) begin
      pstate <= pstate_e'(mode_req);
      rdy    <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) rdy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_lock <= 1'b1;
    else if (wake_wr) wr_lock <= 1'b1;
    else if (rd_ok)   wr_lock <= 1'b0;
  end

  a_r2_sleep_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != PS_RUN) |-> !rdy);
  a_r5_wake_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake_wr |=> (pstate == PS_RUN) && !rdy);
  a_r10_lock_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_wr |=> wr_lock);
  a_r1_ready_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (pstate == PS_RUN));

endmodule

// File: rtl/pwr_host.sv
module pwr_host
  import pwrctl_pkg::*;
#(
  parameter int                 ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]  CTL_ADDR     = 8'h54,
  parameter logic [ADDR_W-1:0]  WAKE_ADDR    = 8'h64,
  parameter logic [ADDR_W-1:0]  SCR_ADDR     = 8'h10,
  parameter logic [31:0]        WAKE_PATTERN = 32'hA5C3_0F96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  pstate_e           pstate,
  input  logic              rdy,
  input  logic              wr_lock,
  input  logic [31:0]       ctrl_word,
  output logic              ctrl_wr,
  output logic              wake_wr,
  output logic              rd_ok,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  logic        hit_ctl, hit_wake, hit_scr;
  logic        wr_ok, scr_wr;
  logic [31:0] scratch;
  logic [31:0] rd_mux;

  assign hit_ctl  = (addr == CTL_ADDR);
  assign hit_wake = (addr == WAKE_ADDR);
  assign hit_scr  = (addr == SCR_ADDR);

  assign rd_ok   = rd && (rdy || hit_ctl);
  assign wr_ok   = wr && rdy && !wr_lock;
  assign ctrl_wr = wr_ok && hit_ctl;
  assign scr_wr  = wr_ok && hit_scr;
  assign wake_wr = wr && hit_wake && (pstate != PS_RUN);

  always_comb begin
    if (hit_ctl)       rd_mux = ctrl_word;
    else if (hit_scr)  rd_mux = scratch;
    else if (hit_wake) rd_mux = WAKE_PATTERN;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid  <= 1'b0;
      rdata   <= '0;
      scratch <= '0;
    end else begin
      rvalid <= rd_ok;
      rdata  <= rd_ok ? rd_mux : '0;
      if (scr_wr) scratch <= wdata;
    end
  end

  a_r3_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rdy && !hit_ctl) |=> !rvalid);
  a_r4_scratch_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(scratch));
  a_r4_no_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> rdy && (pstate == PS_RUN));

endmodule

// File: rtl/pwr_wake.sv
module pwr_wake
  import pwrctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pstate_e    pstate,
  input  logic       frame_det,
  input  logic       magic_det,
  input  logic       ctrl_wr,
  input  logic [2:0] en_wdata,
  input  logic [1:0] wst_clr,
  input  logic       pint_clr,
  output logic [2:0] en_q,
  output logic [1:0] wst,
  output logic       pint,
  output logic       pme_o,
  output logic       irq_o
);
  logic detect;

  assign detect = (frame_det || magic_det) && (pstate == PS_DOZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      wst  <= '0;
      pint <= 1'b0;
    end else if (detect) begin
      wst  <= 2'b10;
      pint <= 1'b1;
    end else if (ctrl_wr) begin
      en_q <= en_wdata;
      wst  <= wst & ~wst_clr;
      pint <= pint & ~pint_clr;
    end
  end

  assign pme_o = wst[1] && en_q[0] && en_q[1];
  assign irq_o = pint && en_q[2];

  a_r7_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_det || magic_det) && pstate == PS_DOZE) |=> (wst == 2'b10) && pint);
  a_r7_ignored_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != PS_DOZE && !ctrl_wr) |=> $stable(wst) && $stable(pint));
  a_r11_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pint) |-> $past(ctrl_wr));

endmodule

// File: rtl/pwr_clk.sv
module pwr_clk
  import pwrctl_pkg::*;
#(
  parameter int              NDOM      = 4,
  parameter logic [NDOM-1:0] DOZE_KEEP = 4'b0011
) (
  input  pstate_e         pstate,
  output logic [NDOM-1:0] cke
);
  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    assign cke[i] = (pstate == PS_RUN) || ((pstate == PS_DOZE) && DOZE_KEEP[i]);
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwrctl_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter int                RESUME_CYC   = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR     = 8'h54,
  parameter logic [ADDR_W-1:0] WAKE_ADDR    = 8'h64,
  parameter logic [ADDR_W-1:0] SCR_ADDR     = 8'h10,
  parameter logic [31:0]       WAKE_PATTERN = 32'hA5C3_0F96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              wake_frame_det,
  input  logic              magic_pkt_det,
  output logic              pme_o,
  output logic              irq_o,
  output logic              phy_clk_en,
  output logic              mac_wake_clk_en,
  output logic              mac_clk_en,
  output logic              core_clk_en
);
  localparam int NDOM = 4;

  pstate_e         pstate;
  logic            rdy, wr_lock, ctrl_wr, wake_wr, rd_ok, pint;
  logic [2:0]      en_q;
  logic [1:0]      wst;
  logic [31:0]     ctrl_word;
  logic [NDOM-1:0] cke;

  assign ctrl_word = ctrl_pack(rdy, en_q, wst, pstate, pint);

  pwr_host #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .WAKE_ADDR(WAKE_ADDR),
    .SCR_ADDR(SCR_ADDR), .WAKE_PATTERN(WAKE_PATTERN)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .wdata(host_wdata), .pstate(pstate), .rdy(rdy), .wr_lock(wr_lock),
    .ctrl_word(ctrl_word), .ctrl_wr(ctrl_wr), .wake_wr(wake_wr), .rd_ok(rd_ok),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  pwr_seq #(.RESUME_CYC(RESUME_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .mode_req(host_wdata[CF_MODE+1:CF_MODE]), .wake_wr(wake_wr), .rd_ok(rd_ok),
    .pstate(pstate), .rdy(rdy), .wr_lock(wr_lock)
  );

  pwr_wake u_wake (
    .clk(clk), .rst_n(rst_n), .pstate(pstate), .frame_det(wake_frame_det),
    .magic_det(magic_pkt_det), .ctrl_wr(ctrl_wr),
    .en_wdata(host_wdata[CF_IRQ_EN:CF_PME_EN]),
    .wst_clr(host_wdata[CF_WST+1:CF_WST]), .pint_clr(host_wdata[CF_PINT]),
    .en_q(en_q), .wst(wst), .pint(pint), .pme_o(pme_o), .irq_o(irq_o)
  );

  pwr_clk #(.NDOM(NDOM), .DOZE_KEEP(4'b0011)) u_clk (
    .pstate(pstate), .cke(cke)
  );

  assign phy_clk_en      = cke[0];
  assign mac_wake_clk_en = cke[1];
  assign mac_clk_en      = cke[2];
  assign core_clk_en     = cke[3];

  a_r6_core_off_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != PS_RUN) |-> !core_clk_en && !mac_clk_en);
  a_r6_phy_on_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> phy_clk_en && mac_wake_clk_en);

endmodule

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
  localparam int          RES  = 16;
  localparam logic [7:0]  CTL  = 8'h54;
  localparam logic [7:0]  WAK  = 8'h64;
  localparam logic [7:0]  SCR  = 8'h10;
  localparam logic [31:0] PAT  = 32'hA5C3_0F96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        wf = 1'b0, mp = 1'b0;
  logic        pme_o, irq_o, phy_clk_en, mac_wake_clk_en, mac_clk_en, core_clk_en;

  int vectors = 0;
  int miscmp  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .wake_frame_det(wf), .magic_pkt_det(mp),
    .pme_o(pme_o), .irq_o(irq_o), .phy_clk_en(phy_clk_en),
    .mac_wake_clk_en(mac_wake_clk_en), .mac_clk_en(mac_clk_en),
    .core_clk_en(core_clk_en)
  );

  // Behavioural reference model
  int          m_st = 0, m_cnt = RES;
  bit          m_rdy = 0, m_lock = 1, m_pint = 0, m_rdv = 0;
  bit [2:0]    m_en = 0;
  bit [1:0]    m_wst = 0;
  bit [31:0]   m_scr = 0, m_rdata = 0;
  bit          rd_h, wr_h, wake_w, det;
  bit [31:0]   rv;
  int          mreq;

  function automatic bit [31:0] m_ctrl();
    return {15'd0, m_pint, 2'd0, 2'(m_st), 6'd0, m_wst, m_en, m_rdy};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = RES; m_rdy = 0; m_lock = 1; m_pint = 0; m_rdv = 0;
      m_en = 0; m_wst = 0; m_scr = 0; m_rdata = 0;
    end else begin
      rd_h   = host_rd && (m_rdy || host_addr == CTL);
      rv     = (host_addr == CTL) ? m_ctrl() : (host_addr == SCR) ? m_scr :
               (host_addr == WAK) ? PAT : 32'd0;
      wake_w = host_wr && host_addr == WAK && m_st != 0;
      wr_h   = host_wr && m_rdy && !m_lock;
      det    = (wf || mp) && m_st == 1;
      mreq   = int'(host_wdata[13:12]);
      m_rdv  = rd_h;
      m_rdata = rd_h ? rv : 32'd0;
      if (wr_h && host_addr == SCR) m_scr = host_wdata;
      if (det) begin m_wst = 2'b10; m_pint = 1; end
      else if (wr_h && host_addr == CTL) begin
        m_en = host_wdata[3:1];
        m_wst = m_wst & ~host_wdata[5:4];
        m_pint = m_pint & ~host_wdata[16];
      end
      if (wake_w) begin m_st = 0; m_cnt = RES; m_rdy = 0; end
      else if (wr_h && host_addr == CTL && (mreq == 1 || mreq == 2)) begin
        m_st = mreq; m_rdy = 0;
      end else if (m_cnt > 0) begin
        m_cnt--; if (m_cnt == 0) m_rdy = 1;
      end
      if (wake_w) m_lock = 1; else if (rd_h) m_lock = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R13 rvalid", 32'(host_rvalid), 32'(m_rdv));
    chk("R13 rdata", host_rdata, m_rdata);
    chk("R6 cke", {28'd0, core_clk_en, mac_clk_en, mac_wake_clk_en, phy_clk_en},
        {28'd0, m_st == 0, m_st == 0, m_st != 2, m_st != 2});
    chk("R8 pme", 32'(pme_o), 32'(m_wst[1] & m_en[0] & m_en[1]));
    chk("R9 irq", 32'(irq_o), 32'(m_pint & m_en[2]));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic v, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    tick();
    host_rd = 1'b0; v = host_rvalid; d = host_rdata;
  endtask

  task automatic pulse(bit frame);
    if (frame) wf = 1'b1; else mp = 1'b1;
    tick();
    wf = 1'b0; mp = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscmp++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic v;
    logic [31:0] d;
    repeat (3) tick();
    chk("R1 reset cke", {28'd0, core_clk_en, mac_clk_en, mac_wake_clk_en, phy_clk_en}, 32'hF);
    chk("R1 reset pme", 32'(pme_o), 0);
    rst_n = 1'b1;
    rd(SCR, v, d); chk("R3 read refused before ready", 32'(v), 0);
    repeat (20) tick();
    wr(SCR, 32'h1234);
    rd(SCR, v, d); chk("R10 write blocked before first read", d, 0);
    wr(SCR, 32'hCAFE_F00D);
    rd(SCR, v, d); chk("R12 scratch written", d, 32'hCAFE_F00D);
    rd(CTL, v, d); chk("R1 ctrl after reset", d, 32'h1);
    rd(WAK, v, d); chk("R13 wake pattern", d, PAT);
    wr(CTL, 32'h3000 | 32'hE);
    rd(CTL, v, d); chk("R2 reserved mode", d, 32'hF);
    wr(CTL, 32'h1000 | 32'hE);
    chk("R6 doze phy", 32'(phy_clk_en), 1);
    chk("R6 doze core", 32'(core_clk_en), 0);
    rd(SCR, v, d); chk("R3 scratch read refused", 32'(v), 0);
    rd(CTL, v, d); chk("R2 doze entry", d, 32'h100E);
    wr(SCR, 32'h0);
    wr(CTL, 32'h0);
    pulse(1'b1);
    chk("R8 pme with both enables", 32'(pme_o), 1);
    chk("R9 irq raised", 32'(irq_o), 1);
    rd(CTL, v, d); chk("R7 frame detect", d, 32'h1_102E);
    wr(WAK, 32'hDEAD);
    repeat (RES - 1) tick();
    rd(CTL, v, d); chk("R5 still resuming", d, 32'h1_002E);
    rd(CTL, v, d); chk("R5 ready after delay", d, 32'h1_002F);
    rd(SCR, v, d); chk("R4 sleep write dropped", d, 32'hCAFE_F00D);
    wr(CTL, 32'h0001_0032);
    rd(CTL, v, d); chk("R11 w1c clear", d, 32'h3);
    wr(WAK, 32'h0);
    rd(CTL, v, d); chk("R5 wake write in run", d, 32'h3);
    wr(CTL, 32'h2000 | 32'hE);
    chk("R6 off all gated", {28'd0, core_clk_en, mac_clk_en, mac_wake_clk_en, phy_clk_en}, 0);
    pulse(1'b0);
    wr(WAK, 32'h1);
    repeat (RES + 4) tick();
    wr(SCR, 32'h55);
    rd(SCR, v, d); chk("R10 blocked after wake", d, 32'hCAFE_F00D);
    rd(CTL, v, d); chk("R7 detect ignored in off", d, 32'hF);
    wr(SCR, 32'h55);
    rd(SCR, v, d); chk("R12 write after unlock", d, 32'h55);
    wr(CTL, 32'h1002);
    pulse(1'b0);
    chk("R8 pme needs wol enable", 32'(pme_o), 0);
    chk("R9 irq disabled", 32'(irq_o), 0);
    wr(WAK, 32'h7);
    repeat (RES + 2) tick();
    rd(CTL, v, d); chk("R7 magic in doze", d, 32'h1_0023);
    pulse(1'b1);
    rd(CTL, v, d); chk("R7 detect ignored in run", d, 32'h1_0023);
    wr(CTL, 32'h0001_0030);
    rd(CTL, v, d); chk("R11 cleared", d, 32'h1);
    repeat (3) tick();
    finish_run();
  end
endmodule